// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serializer

This block turns a stereo sample pair into the three-wire serial stream an external DAC expects: a bit clock, a word-select line that marks the channel, and a serial data line. The bit clock is the system clock divided by a fixed ratio. With the default ratio of 4 and a 9.6 MHz system clock, the bit clock runs at 2.4 MHz. Each stereo frame is 64 bit clocks long, which gives a 37.5 kHz sample rate.

A single format pin selects the frame layout, and the selection can change while the block runs. With the pin low, the frame is I2S: the MSB starts one bit after the channel edge, and a width code truncates each sample to its top 16, 18 or 20 bits. With the pin high, the frame is 16-bit right-justified: the data is packed against the end of each half-frame, and the word-select polarity is inverted.

At the start of every frame the block copies the sample pair, the format and the width into shadow registers. At the same time it raises a one-cycle request, and the sample source answers by presenting the next pair. Nothing on the inputs affects a frame once that frame has started.

Top module: `dual_fmt_audio_ser`

## Requirements
- R1: While rst_ni is low, bclk_o, ws_o, sd_o and req_o are all 0.
- R2: bclk_o has a period of CLK_DIV system clocks and is high for CLK_DIV/2 of them (default: period 4, high for 2).
- R3: A frame is 2*SLOT_BITS (64) bit clocks long. req_o is high for exactly one system clock per frame, in the cycle where bclk_o falls to begin bit 0 of the frame. The first request comes CLK_DIV clocks after reset is released.
- R4: ws_o, sd_o and req_o change only when bclk_o falls, so they are stable around every rising edge of bclk_o.
- R5: With fmt_rj_i = 0 (I2S), ws_o is 0 for bits 0..31 (left) and 1 for bits 32..63 (right). Each half sends MSB first, and its MSB is at position 1 of the half.
- R6: In I2S, width_sel_i selects the number of bits sent: 00 = 16, 01 = 18, 10 and 11 = 20. The top w bits of the 20-bit sample fill positions 1..w of the half. Position 0 and positions after the LSB are 0.
- R7: With fmt_rj_i = 1 (right-justified), ws_o is 1 for the left half and 0 for the right half. Sample bits [19:4] are sent MSB first in positions 16..31 of each half, so the LSB is the last bit before the word-select change. Positions 0..15 are 0. width_sel_i has no effect in this format.
- R8: left_i and right_i are sampled only in the req_o cycle. Changes to them during a frame do not alter that frame.
- R9: fmt_rj_i and width_sel_i are sampled only in the req_o cycle. A change during a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (256 x sample rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_rj_i | input | 1 | 0 = I2S, 1 = 16-bit right-justified |
| width_sel_i | input | 2 | I2S word width code (16/18/20) |
| left_i | input | SAMPLE_W | Left sample, signed |
| right_i | input | SAMPLE_W | Right sample, signed |
| req_o | output | 1 | One-cycle pulse: pair taken, present next |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select (channel marker) |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The bench runs frames that alternate between the two formats and cover every width code. The samples include all-ones and lone-MSB patterns, which expose an off-by-one alignment. A mapper that drops the one-bit I2S delay, or that pads on the wrong side in the right-justified format, produces bits shifted by one or sixteen positions at the bit-clock rising edge. In some frames the bench drives the opposite format, a different width code and inverted samples for part of the frame, then restores the intended values. A design that reads these inputs through during the frame, instead of holding them in shadow registers, alters the frame in flight. The bench also times req_o and each bit-clock phase, so a wrong divider or a frame of 63 or 65 bits shows up as a wrong cycle count.

// File: rtl/dual_fmt_audio_ser_pkg.sv
package dual_fmt_audio_ser_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;

  typedef enum logic [1:0] {
    WID_16 = 2'b00,
    WID_18 = 2'b01,
    WID_20 = 2'b10,
    WID_MX = 2'b11
  } wid_e;

  function automatic int width_bits(input logic [1:0] code, input int max_w);
    int w;
    case (code)
      WID_16:  w = 16;
      WID_18:  w = 18;
      default: w = 20;
    endcase
    return (w > max_w) ? max_w : w;
  endfunction

endpackage

// File: rtl/ser_clk_div.sv
module ser_clk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rise_o,
  output logic fall_o
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            div_q <= '0;
    else if (div_q == DIV_W'(CLK_DIV - 1))  div_q <= '0;
    else                                    div_q <= div_q + 1'b1;
  end

  assign rise_o = (div_q == DIV_W'(HALF - 1));
  assign fall_o = (div_q == DIV_W'(CLK_DIV - 1));
endmodule

// File: rtl/ser_frame_ctr.sv
module ser_frame_ctr #(
  parameter int FRAME_BITS = 64,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [BIT_W-1:0] bit_nxt_o,
  output logic             start_o
);
  logic [BIT_W-1:0] bit_q;
  logic             last;

  assign last      = (bit_q == BIT_W'(FRAME_BITS - 1));
  assign bit_nxt_o = last ? '0 : bit_q + 1'b1;
  assign start_o   = adv_i && last;

  // parked on the last bit so the first advance opens a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bit_q <= BIT_W'(FRAME_BITS - 1);
    else if (adv_i) bit_q <= bit_nxt_o;
  end
endmodule

// File: rtl/ser_bit_mapper.sv
module ser_bit_mapper
  import dual_fmt_audio_ser_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_BITS = 32,
  parameter int RJ_BITS   = 16,
  localparam int BIT_W  = $clog2(2 * SLOT_BITS),
  localparam int SLOT_W = $clog2(SLOT_BITS)
) (
  input  logic [BIT_W-1:0]    bit_i,
  input  logic                fmt_rj_i,
  input  logic [1:0]          width_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int RJ_START = SLOT_BITS - RJ_BITS;

  logic                hi;
  logic [SAMPLE_W-1:0] smp;
  logic [SAMPLE_W-1:0] sh;
  int                  pos;
  int                  w;

  assign hi  = bit_i[BIT_W-1];
  assign smp = hi ? right_i : left_i;

  always_comb begin
    pos  = 32'(bit_i[SLOT_W-1:0]);
    w    = width_bits(width_i, SAMPLE_W);
    sh   = '0;
    sd_o = 1'b0;
    if (fmt_e'(fmt_rj_i) == FMT_RJ) begin
      ws_o = ~hi;
      if (pos >= RJ_START) begin
        sh   = smp << (pos - RJ_START);
        sd_o = sh[SAMPLE_W-1];
      end
    end else begin
      ws_o = hi;
      if (pos >= 1 && pos <= w) begin
        sh   = smp << (pos - 1);
        sd_o = sh[SAMPLE_W-1];
      end
    end
  end
endmodule

// File: rtl/dual_fmt_audio_ser.sv
module dual_fmt_audio_ser
  import dual_fmt_audio_ser_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int CLK_DIV   = 4,
  parameter int SLOT_BITS = 32,
  parameter int RJ_BITS   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fmt_rj_i,
  input  logic [1:0]          width_sel_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                req_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  logic             rise, fall, start;
  logic [BIT_W-1:0] bit_nxt;

  logic                fmt_q;
  logic [1:0]          wid_q;
  logic [SAMPLE_W-1:0] left_q, right_q;

  logic                m_fmt;
  logic [1:0]          m_wid;
  logic [SAMPLE_W-1:0] m_left, m_right;
  logic                m_ws, m_sd;

  logic bclk_q, ws_q, sd_q, req_q;

  ser_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_o(rise),
    .fall_o(fall)
  );

  ser_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (fall),
    .bit_nxt_o(bit_nxt),
    .start_o  (start)
  );

  // bit 0 of a new frame maps from the live inputs being captured
  assign m_fmt   = start ? fmt_rj_i    : fmt_q;
  assign m_wid   = start ? width_sel_i : wid_q;
  assign m_left  = start ? left_i      : left_q;
  assign m_right = start ? right_i     : right_q;

  ser_bit_mapper #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_BITS(SLOT_BITS),
    .RJ_BITS  (RJ_BITS)
  ) u_map (
    .bit_i   (bit_nxt),
    .fmt_rj_i(m_fmt),
    .width_i (m_wid),
    .left_i  (m_left),
    .right_i (m_right),
    .ws_o    (m_ws),
    .sd_o    (m_sd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= 1'b0;
      wid_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else if (start) begin
      fmt_q   <= fmt_rj_i;
      wid_q   <= width_sel_i;
      left_q  <= left_i;
      right_q <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
      sd_q   <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= start;
      if (rise) bclk_q <= 1'b1;
      if (fall) begin
        bclk_q <= 1'b0;
        ws_q   <= m_ws;
        sd_q   <= m_sd;
      end
    end
  end

  assign bclk_o = bclk_q;
  assign ws_o   = ws_q;
  assign sd_o   = sd_q;
  assign req_o  = req_q;
endmodule

// File: rtl/dual_fmt_audio_ser_chk.sv
module dual_fmt_audio_ser_chk #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic req_o
);
  logic [7:0]  hi_cnt;
  logic [15:0] fall_cnt;
  logic        started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= '0;
      fall_cnt <= '0;
      started  <= 1'b0;
    end else begin
      hi_cnt <= bclk_o ? hi_cnt + 1'b1 : '0;
      if (req_o) begin
        fall_cnt <= '0;
        started  <= 1'b1;
      end else if ($fell(bclk_o)) begin
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

  AST_BCLK_HIGH_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |-> hi_cnt == 8'(CLK_DIV / 2));                 // R2
  AST_FRAME_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && started) |-> fall_cnt == 16'(FRAME_BITS - 1));      // R3
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);                                            // R3
  AST_REQ_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $fell(bclk_o));                                     // R3
  AST_WS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bclk_o));                            // R4
  AST_SD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o));                            // R4
endmodule

bind dual_fmt_audio_ser dual_fmt_audio_ser_chk #(
  .CLK_DIV   (CLK_DIV),
  .FRAME_BITS(2 * SLOT_BITS)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .bclk_o(bclk_o),
  .ws_o  (ws_o),
  .sd_o  (sd_o),
  .req_o (req_o)
);

// File: tb/dual_fmt_audio_ser_test.sv
module dual_fmt_audio_ser_test;
  localparam int NF = 8;
  localparam int FB = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fmt_rj_i = 1'b0;
  logic [1:0]  width_sel_i = 2'b00;
  logic [19:0] left_i = '0, right_i = '0;
  logic        req_o, bclk_o, ws_o, sd_o;

  int checks = 0, fails = 0;
  bit mon_done = 0, ended = 0;

  logic [1:0]  exp_q[$];
  string       tag_q[$];

  logic        fmt_a  [NF];
  logic [1:0]  wsel_a [NF];
  logic [19:0] l_a    [NF];
  logic [19:0] r_a    [NF];
  bit          junk_a [NF];

  always #2 clk = ~clk;

  dual_fmt_audio_ser uut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_rj_i(fmt_rj_i), .width_sel_i(width_sel_i),
    .left_i(left_i), .right_i(right_i), .req_o(req_o), .bclk_o(bclk_o),
    .ws_o(ws_o), .sd_o(sd_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // driver side: build the expected frame straight from R5..R7
  task automatic push_frame(input int k);
    string tsd, tws;
    tws = fmt_a[k] ? "R7" : "R5";
    if (junk_a[k])                          tsd = "R8";
    else if (k > 0 && fmt_a[k] != fmt_a[k-1]) tsd = "R9";
    else                                    tsd = fmt_a[k] ? "R7" : "R6";
    for (int b = 0; b < FB; b++) begin
      int pos, w;
      logic hi, e_ws, e_sd;
      logic [19:0] s;
      hi  = (b >= 32);
      pos = b % 32;
      s   = hi ? r_a[k] : l_a[k];
      w   = (wsel_a[k] == 2'b00) ? 16 : (wsel_a[k] == 2'b01) ? 18 : 20;
      e_sd = 1'b0;
      if (fmt_a[k]) begin
        e_ws = ~hi;
        if (pos >= 16) e_sd = s[19 - (pos - 16)];
      end else begin
        e_ws = hi;
        if (pos >= 1 && pos <= w) e_sd = s[20 - pos];
      end
      exp_q.push_back({e_ws, e_sd});
      tag_q.push_back({tws, ":", tsd});
    end
  endtask

  task automatic drive(input int k);
    fmt_rj_i    = fmt_a[k];
    width_sel_i = wsel_a[k];
    left_i      = l_a[k];
    right_i     = r_a[k];
  endtask

  initial begin
    fmt_a[0]=0; wsel_a[0]=2'b10; l_a[0]=20'h9A5C3; r_a[0]=20'h3F0F1; junk_a[0]=0;
    fmt_a[1]=0; wsel_a[1]=2'b00; l_a[1]=20'h9A5C3; r_a[1]=20'h3F0F1; junk_a[1]=1;
    fmt_a[2]=0; wsel_a[2]=2'b01; l_a[2]=20'h6B2D4; r_a[2]=20'hC1E07; junk_a[2]=0;
    fmt_a[3]=1; wsel_a[3]=2'b10; l_a[3]=20'h9A5C3; r_a[3]=20'h3F0F1; junk_a[3]=0;
    fmt_a[4]=1; wsel_a[4]=2'b00; l_a[4]=20'hF0F0F; r_a[4]=20'h0F0F0; junk_a[4]=1;
    fmt_a[5]=0; wsel_a[5]=2'b11; l_a[5]=20'hA5A5A; r_a[5]=20'h5A5A5; junk_a[5]=0;
    fmt_a[6]=0; wsel_a[6]=2'b10; l_a[6]=20'hFFFFF; r_a[6]=20'h80000; junk_a[6]=1;
    fmt_a[7]=1; wsel_a[7]=2'b01; l_a[7]=20'h00010; r_a[7]=20'h7FFF0; junk_a[7]=0;

    drive(0);
    repeat (5) @(negedge clk);
    check("R1 bclk in reset", 32'(bclk_o), 0);
    check("R1 ws in reset",   32'(ws_o),   0);
    check("R1 sd in reset",   32'(sd_o),   0);
    check("R1 req in reset",  32'(req_o),  0);
    rst_ni = 1'b1;
    push_frame(0);
    @(negedge clk);
    check("R3 no early req", 32'(req_o), 0);
    for (int k = 0; k < NF; k++) begin
      while (!req_o) @(negedge clk);
      if (k + 1 < NF) begin
        if (junk_a[k+1]) begin
          fmt_rj_i    = ~fmt_a[k+1];
          width_sel_i = ~wsel_a[k+1];
          left_i      = ~l_a[k+1];
          right_i     = ~r_a[k+1];
          repeat (90) @(negedge clk);
        end
        drive(k + 1);
        push_frame(k + 1);
      end
      @(negedge clk);
    end
    wait (mon_done);
    finish_run();
  end

  // monitor: compare at every bit-clock rising edge
  initial begin
    int popped, gap, rise_gap;
    bit prev_b, prev_r, seen_rise;
    logic cap_ws, cap_sd;
    logic [1:0] e;
    string t;
    popped = 0; gap = 0; rise_gap = 0; seen_rise = 0; cap_ws = 0; cap_sd = 0;
    wait (rst_ni);
    @(negedge clk);
    while (!req_o) @(negedge clk);
    prev_b = bclk_o;
    prev_r = 1'b1;
    while (popped < NF * FB) begin
      @(negedge clk);
      gap++;
      rise_gap++;
      if (req_o) begin
        check("R3 req gap", 32'(gap), 32'(FB * 4));
        gap = 0;
      end
      if (req_o && prev_r) check("R3 req width", 32'(prev_r), 0);
      if (bclk_o && !prev_b) begin
        if (seen_rise) check("R2 bclk period", 32'(rise_gap), 4);
        seen_rise = 1;
        rise_gap  = 0;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t.substr(0, 1), " ws bit"}, 32'(ws_o), 32'(e[1]));
        check({t.substr(3, 4), " sd bit"}, 32'(sd_o), 32'(e[0]));
        cap_ws = ws_o;
        cap_sd = sd_o;
        popped++;
      end else if (bclk_o && prev_b) begin
        check("R4 ws stable high", 32'(ws_o), 32'(cap_ws));
        check("R4 sd stable high", 32'(sd_o), 32'(cap_sd));
      end
      prev_b = bclk_o;
      prev_r = req_o;
    end
    mon_done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      finish_run();
    end
  end
endmodule